// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Port

This block is the slave side of an I2C control port. A host on the two-wire bus uses it to write and read bytes in a register file that sits beside it. Both bus lines are sampled with the system clock through a short synchronizer. Edge detection on the synchronized lines finds the bus conditions and the clock edges. The block never drives SDA high. It only asks the pad to pull the line low, through an output enable.

A transfer opens with a START and a byte that holds the 7-bit device address and the direction bit. The device address is one of four fixed values, and two strap inputs pick which one. In a write, the next byte sets an 8-bit register pointer and each byte after it is written to that pointer. A read is done in two steps. First the host writes the pointer. It then sends a repeated START with the direction bit set, and the block shifts out the byte at the pointer. A mode input can turn reads off. A START or STOP that arrives in the middle of a byte or a transfer drops what was in progress.

Top module: `i2c_regslave`

## Requirements
- R1: During and right after a synchronous reset, `sda_oe` is 0 and `reg_we` is 0.
- R2: SDA is open drain. `sda_oe` = 1 pulls the line low. A 1 bit, a release and every idle bit leave `sda_oe` at 0, so the line is high only through the external pull-up.
- R3: A falling SDA edge while SCL is high is a START. It opens an address phase that shifts in eight bits, MSB first, on SCL rising edges. The byte is the 7-bit device address followed by a direction bit, where 1 means read and 0 means write.
- R4: The 7-bit device address is {0011, not strap[1], 1, strap[0]}. In 8-bit form with a write bit, strap 00 gives 3Ch, 01 gives 3Eh, 10 gives 34h and 11 gives 36h. On a match, the block holds SDA low through the ninth SCL pulse.
- R5: When the address byte does not match, the block gives no acknowledge. It then ignores every later byte until the next START.
- R6: While `wr_only` = 1, an address byte with the read bit set is not acknowledged. Address bytes with the write bit set are still acknowledged.
- R7: In a write, the block acknowledges the register-pointer byte and every data byte. Each data byte produces one `reg_we` pulse, one clock long, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. Further data bytes in the same transfer write the same pointer.
- R8: A read shifts out `reg_rdata` for the current pointer, MSB first. A master acknowledge sends the byte again. A master non-acknowledge makes the block release SDA and go idle.
- R9: A START seen in the middle of a byte drops the partial byte without any write and begins a new address phase.
- R10: A STOP seen at any point returns the block to idle. Bytes clocked after it, with no START, are not acknowledged.
- R11: `sda_oe` changes only while the synchronized SCL is low, so the block never creates a START or STOP of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 2 | Selects one of four device addresses |
| wr_only | input | 1 | 1 refuses read requests |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | Write strobe, one clock long |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
A pin change reaches the control logic three clock edges later: two synchronizer stages, then the edge register. The acknowledge enable and the write strobe therefore appear three edges after the SCL fall that closes a byte. A returned data bit appears the same number of edges after the preceding SCL fall. The bench holds each SCL phase for eight clocks and samples SDA in the middle of the high phase, at least twelve clocks after the fall that set the bit up. Written registers are compared whenever the strobe fires, against an ordered queue of expected writes, so the bench does not depend on the exact strobe cycle.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    localparam int BYTE_W    = 8;
    localparam int DEV_W     = 7;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [3:0] DEV_HI = 4'b0011;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK
    } xfer_state_t;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [DEV_W-1:0] dev_addr_of(input logic [1:0] strap);
        return {DEV_HI, ~strap[1], 1'b1, strap[0]};
    endfunction

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense
    import i2c_regslave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q = scl_sh[STAGES-1];
    assign sda_q = sda_sh[STAGES-1];

    always_comb begin
        ev.scl_lvl  = scl_q;
        ev.sda_lvl  = sda_q;
        ev.scl_rise = scl_q & ~scl_d;
        ev.scl_fall = ~scl_q & scl_d;
        ev.start    = scl_q & scl_d & sda_d & ~sda_q;
        ev.stop     = scl_q & scl_d & ~sda_d & sda_q;
    end
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
    import i2c_regslave_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [DEV_W-1:0] dev_addr,
    input  logic             wr_only,
    input  byte_t            reg_rdata,
    output logic             sda_oe,
    output byte_t            reg_addr,
    output byte_t            reg_wdata,
    output logic             reg_we
);
    xfer_state_t      state, resume;
    byte_t            shreg, txb, ptr;
    logic [CNT_W-1:0] cnt;
    logic             mnack;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            resume    <= ST_IDLE;
            shreg     <= '0;
            txb       <= '0;
            ptr       <= '0;
            cnt       <= '0;
            mnack     <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (ev.start) begin
                state  <= ST_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WDATA: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[BYTE_W-1:1] == dev_addr && !(shreg[0] && wr_only)) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    resume <= shreg[0] ? ST_TX : ST_REG;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (state == ST_REG) begin
                                    ptr <= shreg;
                                end else begin
                                    reg_we    <= 1'b1;
                                    reg_wdata <= shreg;
                                end
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                resume <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            state <= resume;
                            cnt   <= '0;
                            if (resume == ST_TX) begin
                                txb    <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                txb    <= {txb[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txb[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            mnack <= ev.sda_lvl;
                        end else if (ev.scl_fall) begin
                            cnt <= '0;
                            if (mnack) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_TX;
                                txb    <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr = ptr;

    // R3: a START always opens a fresh address phase
    assert_start_opens_addr_R3: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_DEV && cnt == '0));

    // R10: a STOP always leaves the block idle with the line released
    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_oe));

    // R2: the line is pulled low only in acknowledge or transmit phases
    assert_drive_phase_only_R2: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ACK || state == ST_TX));

    // R11: the enable moves only while the synchronized clock is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(ev.scl_lvl) || $past(ev.start) || $past(ev.stop)));

    // R7: each write strobe is a single clock wide
    assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6: with reads refused, an acknowledge never leads into transmit
    assert_no_read_when_wronly_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && wr_only) |-> (resume != ST_TX));
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_strap,
    input  logic       wr_only,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    bus_ev_t          ev;
    logic [DEV_W-1:0] dev_addr;

    assign dev_addr = dev_addr_of(addr_strap);

    i2c_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_xfer_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .dev_addr  (dev_addr),
        .wr_only   (wr_only),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );

    // R1: nothing is driven in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !reg_we));
endmodule

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       scl;
    logic       m_sda;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] strap;
    logic       wr_only;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;

    logic [7:0]  regs [256];
    logic [15:0] exp_q [$];
    int n_checks = 0;
    int n_errs   = 0;
    int oe_bad   = 0;
    logic prev_oe = 1'b0;
    logic ack;
    logic [7:0] rb, rb2;

    always #5 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_regslave uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .wr_only    (wr_only),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    // write scoreboard monitor (R7, R9)
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            regs[reg_addr] = reg_wdata;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R7", "write addr/data",
                    {reg_addr, reg_wdata}, e);
            end
        end
    end

    // R11 monitor: enable must not move while the bus clock is high
    always @(posedge clk) begin
        if (!rst && sda_oe != prev_oe && scl) oe_bad <= oe_bad + 1;
        prev_oe <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q);
            scl   = 1'b1; tick(Q);
            scl   = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q / 2);
        acked = ~sda_line; tick(Q / 2);
        scl   = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            scl   = 1'b1; tick(Q / 2);
            b[i]  = sda_line; tick(Q / 2);
            scl   = 1'b0;
        end
        m_sda = nack; tick(Q);
        scl   = 1'b1; tick(Q);
        scl   = 1'b0;
    endtask

    function automatic logic [6:0] addr_of(input logic [1:0] s);
        case (s)
            2'd0: return 7'h1E;
            2'd1: return 7'h1F;
            2'd2: return 7'h1A;
            default: return 7'h1B;
        endcase
    endfunction

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d);
        bus_start();
        send_byte({dev, 1'b0}, ack);
        chk(ack, "R4", "device address ack", ack, 1);
        send_byte(ra, ack);
        chk(ack, "R7", "pointer byte ack", ack, 1);
        exp_q.push_back({ra, d});
        send_byte(d, ack);
        chk(ack, "R7", "data byte ack", ack, 1);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] ra, input logic [7:0] e);
        bus_start();
        send_byte({addr_of(strap), 1'b0}, ack);
        chk(ack, "R3", "address after START", ack, 1);
        send_byte(ra, ack);
        chk(ack, "R8", "pointer ack", ack, 1);
        bus_start();
        send_byte({addr_of(strap), 1'b1}, ack);
        chk(ack, "R8", "read address ack", ack, 1);
        recv_byte(rb, 1'b1);
        chk(rb == e, "R8", "read byte (R2 open drain ones)", rb, e);
        bus_stop();
    endtask

    initial begin
        scl = 1'b1; m_sda = 1'b1; strap = 2'd0; wr_only = 1'b0; rst = 1'b1;
        for (int i = 0; i < 256; i++) regs[i] = 8'h00;
        regs[8'h20] = 8'h3C;
        tick(5);
        rst = 1'b0;
        tick(1);
        chk(!sda_oe && !reg_we, "R1", "outputs after reset", {sda_oe, reg_we}, 0);
        tick(2);

        // R4: all four strap settings
        do_write(addr_of(2'd0), 8'h10, 8'hA5);
        for (int s = 1; s < 4; s++) begin
            strap = 2'(s);
            tick(4);
            do_write(addr_of(2'(s)), 8'h40 + 8'(s), 8'h11 * 8'(s));
        end

        // R5: wrong address, then a further byte with no START
        strap = 2'd2; tick(4);
        bus_start();
        send_byte({7'h1E, 1'b0}, ack);
        chk(!ack, "R5", "mismatched address nack", ack, 0);
        send_byte(8'h10, ack);
        chk(!ack, "R5", "byte after mismatch ignored", ack, 0);
        bus_stop();

        // R7: two data bytes land on the same pointer
        strap = 2'd0; tick(4);
        bus_start();
        send_byte({addr_of(2'd0), 1'b0}, ack);
        chk(ack, "R4", "device address ack", ack, 1);
        send_byte(8'h50, ack);
        exp_q.push_back({8'h50, 8'hC3});
        send_byte(8'hC3, ack);
        chk(ack, "R7", "first data ack", ack, 1);
        exp_q.push_back({8'h50, 8'h5A});
        send_byte(8'h5A, ack);
        chk(ack, "R7", "second data ack", ack, 1);
        bus_stop();

        // R8 / R2: reads
        do_read(8'h20, 8'h3C);
        do_read(8'h10, 8'hA5);

        // R8: master ack repeats the byte
        bus_start();
        send_byte({addr_of(2'd0), 1'b0}, ack);
        send_byte(8'h50, ack);
        bus_start();
        send_byte({addr_of(2'd0), 1'b1}, ack);
        recv_byte(rb, 1'b0);
        recv_byte(rb2, 1'b1);
        chk(rb == 8'h5A, "R8", "first byte with master ack", rb, 8'h5A);
        chk(rb2 == 8'h5A, "R8", "repeated byte", rb2, 8'h5A);
        bus_stop();

        // R6: write-only mode
        wr_only = 1'b1; tick(4);
        bus_start();
        send_byte({addr_of(2'd0), 1'b1}, ack);
        chk(!ack, "R6", "read refused", ack, 0);
        bus_stop();
        do_write(addr_of(2'd0), 8'h60, 8'h99);
        wr_only = 1'b0; tick(4);

        // R9: START in the middle of a data byte
        bus_start();
        send_byte({addr_of(2'd0), 1'b0}, ack);
        send_byte(8'h30, ack);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte({addr_of(2'd0), 1'b0}, ack);
        chk(ack, "R9", "address after mid-byte START", ack, 1);
        send_byte(8'h31, ack);
        exp_q.push_back({8'h31, 8'h77});
        send_byte(8'h77, ack);
        chk(ack, "R9", "data after restart", ack, 1);
        bus_stop();

        // R10: STOP in the middle of the pointer byte
        bus_start();
        send_byte({addr_of(2'd0), 1'b0}, ack);
        send_bits(8'h00, 3);
        bus_stop();
        scl = 1'b0; tick(Q);
        send_byte({addr_of(2'd0), 1'b0}, ack);
        chk(!ack, "R10", "byte after STOP without START", ack, 0);
        bus_stop();

        tick(20);
        chk(exp_q.size() == 0, "R7", "expected writes left", exp_q.size(), 0);
        chk(oe_bad == 0, "R11", "enable changes while SCL high", oe_bad, 0);
        summary();
    end
endmodule